// File: doc/BRIEF.md
# Floating-Point Status and Condition Register Unit

This unit keeps two 32-bit architectural registers: a floating-point status and control word and the condition register. It executes the register-move instructions that touch them: set one status bit, clear one status bit, load one 4-bit status field from an immediate, load any subset of status fields from a source operand under an 8-bit field mask, copy one status field into one condition field, and read the whole status word. Both registers are visible on output ports so that neighbouring logic can observe them continuously.

The unit sits beside the floating-point issue logic. One instruction word may be presented per cycle with a valid strobe. The unit decodes its fixed fields, rejects illegal encodings with a one-cycle flag, and updates its registers at the clock edge. When status field 1 or field 2 is copied into a condition field, that status field is cleared as a side effect, because both hold sticky exception flags. Record forms clear the upper three bits of condition field 1 and keep its summary-overflow bit. A read returns the status word zero-extended to 64 bits with a one-cycle valid strobe. Arithmetic, rounding and automatic summary-bit generation happen elsewhere.

Top module: `fp_status_unit`

## Requirements
- R1: After reset both registers read zero, and the illegal flag and the result-valid strobe are low.
- R2: A word with primary opcode 63 (bits 31:26) and extended opcode 38 (bits 10:1) sets status bit n, where n is bits 25:21 and the numbering is big-endian, so register bit (31 − n) changes.
- R3: Extended opcode 70 clears status bit n, numbered as in R2.
- R4: Extended opcode 134 writes the immediate in bits 15:12 into status field f given by bits 25:23. Field f occupies register bits [31−4f : 28−4f], so field 0 is the top nibble. The other fields keep their values.
- R5: Extended opcode 711 takes a field mask from bits 24:17. For each field f from 0 to 7, if mask bit (7 − f) is set, status field f takes field f of the low 32 bits of the source operand. Unselected fields keep their values.
- R6: Extended opcode 64 copies status field (bits 20:18) into condition field (bits 25:23). The other condition fields are kept.
- R7: When that copy reads status field 1 or status field 2, the source field is cleared to zero at the same edge. A copy from any other field leaves the status register unchanged.
- R8: Extended opcode 583 drives the status register, zero-extended to 64 bits, on the result output. The result-valid strobe is high for exactly the cycle after the instruction.
- R9: When bit 0 is set on opcode 38, 70, 134, 711 or 583, condition register bits 27:25 are cleared and bit 24 (summary overflow) is kept.
- R10: The following encodings are illegal: opcode 134 with any of bits 22:16 or bit 11 set; opcode 711 with bit 25 or bit 16 set; opcode 64 with bits 15:11 nonzero or with bits 22:21 or 17:16 nonzero. An illegal encoding raises the illegal flag for one cycle and changes neither register.
- R11: A word presented with valid low, or with a primary or extended opcode outside this set, has no effect on either register or on any output strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Instruction word |
| srcOperand | input | 64 | Source floating-point register value for the masked field move |
| fpscrOut | output | 32 | Current status and control register |
| crOut | output | 32 | Current condition register |
| resultData | output | 64 | Zero-extended status word from the last read |
| resultValid | output | 1 | Result data valid, one cycle |
| illegalInst | output | 1 | Illegal encoding seen, one cycle |

## Verification
Both registers are exposed on the ports, so a wrong bit index, a wrong field slice or an incorrect sticky clear shows on the cycle after the instruction. The bench keeps its own copy of both registers and compares it on every cycle. A decode slip on an illegal encoding therefore shows at once as a flag mismatch, or as a register that changed when it should have held. Corruption that builds up over time, such as a record form that drops the summary-overflow bit, is caught because later field copies expose condition field 1 to the comparison.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int REG_W    = 32;
  localparam int FLD_W    = 4;
  localparam int NUM_FLD  = REG_W / FLD_W;
  localparam int RES_W    = 64;
  localparam int BIT_IW   = $clog2(REG_W);
  localparam int FLD_IW   = $clog2(NUM_FLD);
  localparam int CR1_HI   = REG_W - 1 - FLD_W;

  localparam logic [5:0] PRIMARY_OP = 6'd63;
  localparam logic [9:0] XO_SETB = 10'd38;
  localparam logic [9:0] XO_CLRB = 10'd70;
  localparam logic [9:0] XO_FIMM = 10'd134;
  localparam logic [9:0] XO_FMSK = 10'd711;
  localparam logic [9:0] XO_COPY = 10'd64;
  localparam logic [9:0] XO_READ = 10'd583;

  // bit f set: status field f holds sticky flags cleared on copy-out
  localparam logic [NUM_FLD-1:0] STICKY_FLDS = NUM_FLD'(8'b0000_0110);

  typedef struct packed {
    logic                setBit;
    logic                clrBit;
    logic                fldImm;
    logic                fldMask;
    logic                copyFld;
    logic                readAll;
    logic                record;
    logic                illegal;
    logic [BIT_IW-1:0]   bitNum;
    logic [FLD_IW-1:0]   dstFld;
    logic [FLD_IW-1:0]   srcFld;
    logic [FLD_W-1:0]    imm;
    logic [NUM_FLD-1:0]  fldSel;
  } fpsuCmd_t;
endpackage

// File: rtl/fpsu_decode.sv
module fpsu_decode
  import fpsu_pkg::*;
(
  input  logic        instValid,
  input  logic [31:0] instWord,
  output fpsuCmd_t    cmd
);
  logic       isFp;
  logic [9:0] xo;
  logic       recBit;

  always_comb begin
    cmd        = '0;
    isFp       = instValid && (instWord[31:26] == PRIMARY_OP);
    xo         = instWord[10:1];
    recBit     = instWord[0];
    cmd.bitNum = instWord[25:21];
    cmd.dstFld = instWord[25:23];
    cmd.srcFld = instWord[20:18];
    cmd.imm    = instWord[15:12];
    cmd.fldSel = instWord[24:17];
    if (isFp) begin
      case (xo)
        XO_SETB: begin
          cmd.setBit = 1'b1;
          cmd.record = recBit;
        end
        XO_CLRB: begin
          cmd.clrBit = 1'b1;
          cmd.record = recBit;
        end
        XO_FIMM: begin
          if ((|instWord[22:16]) || instWord[11]) cmd.illegal = 1'b1;
          else begin
            cmd.fldImm = 1'b1;
            cmd.record = recBit;
          end
        end
        XO_FMSK: begin
          if (instWord[25] || instWord[16]) cmd.illegal = 1'b1;
          else begin
            cmd.fldMask = 1'b1;
            cmd.record  = recBit;
          end
        end
        XO_COPY: begin
          if ((|instWord[15:11]) || (|instWord[17:16]) || (|instWord[22:21]))
            cmd.illegal = 1'b1;
          else
            cmd.copyFld = 1'b1;
        end
        XO_READ: begin
          cmd.readAll = 1'b1;
          cmd.record  = recBit;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpsu_regs.sv
module fpsu_regs
  import fpsu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  fpsuCmd_t         cmd,
  input  logic [RES_W-1:0] srcOperand,
  output logic [REG_W-1:0] fpscrQ,
  output logic [REG_W-1:0] crQ,
  output logic [RES_W-1:0] resultData,
  output logic             resultValid,
  output logic             illegalQ
);
  logic [REG_W-1:0] fpscrD;
  logic [REG_W-1:0] crD;
  logic [REG_W-1:0] maskMerged;
  int               dstHi;
  int               srcHi;

  // per-field merge for the masked move
  for (genvar g = 0; g < NUM_FLD; g++) begin : gFld
    localparam int HI = REG_W - 1 - FLD_W * g;
    assign maskMerged[HI -: FLD_W] = cmd.fldSel[NUM_FLD-1-g]
                                   ? srcOperand[HI -: FLD_W]
                                   : fpscrQ[HI -: FLD_W];
  end

  always_comb begin
    fpscrD = fpscrQ;
    crD    = crQ;
    dstHi  = REG_W - 1 - FLD_W * int'(cmd.dstFld);
    srcHi  = REG_W - 1 - FLD_W * int'(cmd.srcFld);
    if (cmd.setBit) fpscrD[REG_W-1-int'(cmd.bitNum)] = 1'b1;
    if (cmd.clrBit) fpscrD[REG_W-1-int'(cmd.bitNum)] = 1'b0;
    if (cmd.fldImm) fpscrD[dstHi -: FLD_W] = cmd.imm;
    if (cmd.fldMask) fpscrD = maskMerged;
    if (cmd.copyFld) begin
      crD[dstHi -: FLD_W] = fpscrQ[srcHi -: FLD_W];
      if (STICKY_FLDS[cmd.srcFld]) fpscrD[srcHi -: FLD_W] = '0;
    end
    if (cmd.record) crD[CR1_HI -: FLD_W-1] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fpscrQ      <= '0;
      crQ         <= '0;
      resultData  <= '0;
      resultValid <= 1'b0;
      illegalQ    <= 1'b0;
    end else begin
      fpscrQ      <= fpscrD;
      crQ         <= crD;
      resultValid <= cmd.readAll;
      illegalQ    <= cmd.illegal;
      if (cmd.readAll) resultData <= RES_W'(fpscrQ);
    end
  end

  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.illegal |=> illegalQ && $stable(fpscrQ) && $stable(crQ));

  // R9
  record_keeps_so_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.record |=> (crQ[CR1_HI -: FLD_W-1] == '0) &&
                   (crQ[CR1_HI-FLD_W+1] == $past(crQ[CR1_HI-FLD_W+1])));

  // R8
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.readAll |=> resultValid && (resultData == RES_W'($past(fpscrQ))));

  // R8
  read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.readAll |=> !resultValid);

  // R2
  set_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setBit |=> |(fpscrQ & (REG_W'(1) << (REG_W - 1 - int'($past(cmd.bitNum))))));

  // R7
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.copyFld && STICKY_FLDS[cmd.srcFld]) |=>
      ((fpscrQ >> (REG_W - FLD_W - FLD_W * int'($past(cmd.srcFld)))) & REG_W'(4'hF)) == '0);

  // R11
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.setBit, cmd.clrBit, cmd.fldImm, cmd.fldMask,
              cmd.copyFld, cmd.readAll, cmd.illegal}));
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fpsu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [31:0] instWord,
  input  logic [63:0] srcOperand,
  output logic [31:0] fpscrOut,
  output logic [31:0] crOut,
  output logic [63:0] resultData,
  output logic        resultValid,
  output logic        illegalInst
);
  fpsuCmd_t cmd;

  fpsu_decode u_decode (
    .instValid (instValid),
    .instWord  (instWord),
    .cmd       (cmd)
  );

  fpsu_regs u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .srcOperand  (srcOperand),
    .fpscrQ      (fpscrOut),
    .crQ         (crOut),
    .resultData  (resultData),
    .resultValid (resultValid),
    .illegalQ    (illegalInst)
  );
endmodule

// File: tb/fp_status_unit_bench.sv
module fp_status_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [63:0] srcOperand = '0;
  logic [31:0] fpscrOut, crOut;
  logic [63:0] resultData;
  logic        resultValid, illegalInst;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] mFp = '0;
  logic [31:0] mCr = '0;
  logic        eIll, eRv;
  logic [63:0] eRes;
  string       tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_status_unit u_fp_status_unit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .srcOperand(srcOperand), .fpscrOut(fpscrOut), .crOut(crOut),
    .resultData(resultData), .resultValid(resultValid), .illegalInst(illegalInst)
  );

  function automatic logic [3:0] getFld(input logic [31:0] x, input int f);
    return 4'((x >> (28 - 4*f)) & 32'hF);
  endfunction

  function automatic logic [31:0] putFld(input logic [31:0] x, input int f, input logic [3:0] v);
    return (x & ~(32'hF << (28 - 4*f))) | ({28'h0, v} << (28 - 4*f));
  endfunction

  function automatic logic [31:0] mk(input int xo, input logic [4:0] rd,
                                     input logic [4:0] ra, input logic [4:0] rb, input logic rc);
    return {6'd63, rd, ra, rb, 10'(xo), rc};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic predict(input logic [31:0] w, input logic [63:0] s, input bit v);
    logic [4:0] rd, ra, rb;
    bit ill, rec;
    rd = w[25:21]; ra = w[20:16]; rb = w[15:11];
    ill = 0; rec = 0; eIll = 0; eRv = 0; eRes = '0; tag = "R11";
    if (v && w[31:26] == 6'd63) begin
      case (int'(w[10:1]))
        38: begin tag = "R2"; mFp = mFp | (32'h1 << (31 - int'(rd))); rec = w[0]; end
        70: begin tag = "R3"; mFp = mFp & ~(32'h1 << (31 - int'(rd))); rec = w[0]; end
        134: begin
          tag = "R4";
          if (w[22:16] != 0 || w[11]) ill = 1;
          else begin mFp = putFld(mFp, int'(rd) / 4, w[15:12]); rec = w[0]; end
        end
        711: begin
          tag = "R5";
          if (w[25] || w[16]) ill = 1;
          else begin
            for (int f = 0; f < 8; f++)
              if (w[24 - f]) mFp = putFld(mFp, f, getFld(s[31:0], f));
            rec = w[0];
          end
        end
        64: begin
          tag = "R6";
          if (rb != 0 || ra[1:0] != 0 || rd[1:0] != 0) ill = 1;
          else begin
            mCr = putFld(mCr, int'(rd) / 4, getFld(mFp, int'(ra) / 4));
            if (int'(ra) / 4 == 1 || int'(ra) / 4 == 2) begin
              mFp = putFld(mFp, int'(ra) / 4, 4'h0);
              tag = "R7";
            end
          end
        end
        583: begin tag = "R8"; eRv = 1; eRes = {32'h0, mFp}; rec = w[0]; end
        default: ;
      endcase
      if (ill) begin eIll = 1; tag = "R10"; end
      if (rec) begin mCr = mCr & ~32'h0E00_0000; tag = "R9"; end
    end
  endtask

  task automatic step(input logic [31:0] w, input logic [63:0] s, input bit v);
    instWord = w; srcOperand = s; instValid = v;
    predict(w, s, v);
    @(negedge clk);
    instValid = 1'b0;
    check(fpscrOut == mFp, tag, "status", 64'(fpscrOut), 64'(mFp));
    check(crOut == mCr, tag, "condition", 64'(crOut), 64'(mCr));
    check(illegalInst == eIll, tag, "illegal", 64'(illegalInst), 64'(eIll));
    check(resultValid == eRv, tag, "resultValid", 64'(resultValid), 64'(eRv));
    if (eRv) check(resultData == eRes, tag, "resultData", resultData, eRes);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fpscrOut == 0 && crOut == 0, "R1", "regs", {fpscrOut, crOut}, 64'h0);
    check(!illegalInst && !resultValid, "R1", "strobes",
          64'({illegalInst, resultValid}), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    step(mk(38, 5'd0, 0, 0, 0), 0, 1);            // R2 bit 0 -> MSB
    step(mk(38, 5'd31, 0, 0, 0), 0, 1);           // R2 bit 31 -> LSB
    step(mk(38, 5'd5, 0, 0, 0), 0, 1);            // R2 into field 1
    step(mk(70, 5'd0, 0, 0, 0), 0, 1);            // R3
    step(mk(134, 5'd28, 0, {4'hA, 1'b0}, 0), 0, 1); // R4 field 7
    step(mk(134, 5'd0, 0, {4'h5, 1'b0}, 0), 0, 1);  // R4 field 0
    step(mk(711, {1'b0, 4'h8}, {4'h1, 1'b0}, 0, 0), 64'hFFFF_FFFF_1234_5678, 1); // R5 mask 0x81
    step(mk(711, 5'h0F, 5'h1E, 5'd3, 0), 64'h0BAD_F00D_9ABC_DEF0, 1); // R5 mask 0xFF
    step(mk(64, 5'd28, 5'd4, 0, 0), 0, 1);        // R6/R7 field 1 -> cr 7, cleared
    step(mk(64, 5'd4, 5'd12, 0, 0), 0, 1);        // R6 field 3 -> cr 1, no clear
    step(mk(64, 5'd8, 5'd8, 0, 0), 0, 1);         // R7 field 2 cleared
    step(mk(583, 0, 0, 0, 0), 0, 1);              // R8
    step(mk(38, 5'd7, 0, 0, 1), 0, 1);            // R9 via set bit
    step(mk(583, 0, 0, 0, 1), 0, 1);              // R9 via read
    step(mk(134, 5'd4, 0, {4'h3, 1'b1}, 0), 0, 1);  // R10 bit 11
    step(mk(711, 5'h0F, 5'h1F, 0, 0), 0, 1);      // R10 bit 16
    step(mk(64, 5'd4, 5'd4, 5'd1, 0), 0, 1);      // R10 rb nonzero
    step(mk(64, 5'd5, 5'd4, 0, 0), 0, 1);         // R10 rd low bits
    step(mk(38, 5'd9, 0, 0, 1), 0, 0);            // R11 valid low
    step({6'd31, 26'h0000_04C}, 0, 1);            // R11 other primary
    step(mk(100, 5'd3, 5'd3, 5'd3, 1), 0, 1);     // R11 other extended

    for (int k = 0; k < 800; k++) begin
      logic [31:0] w;
      int xo;
      case ($urandom % 7)
        0: xo = 38; 1: xo = 70; 2: xo = 134; 3: xo = 711;
        4: xo = 64; 5: xo = 583; default: xo = int'($urandom % 1024);
      endcase
      w = $urandom;
      w[31:26] = 6'd63;
      w[10:1] = 10'(xo);
      if ($urandom % 2 == 0) begin
        if (xo == 134) begin w[22:16] = 0; w[11] = 0; end
        if (xo == 711) begin w[25] = 0; w[16] = 0; end
        if (xo == 64) begin w[15:11] = 0; w[17:16] = 0; w[22:21] = 0; end
      end
      step(w, {$urandom, $urandom}, ($urandom % 8) != 0);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule